// File: doc/BRIEF.md
# Queued Lock and Barrier Engine

This block is a shared synchronization coprocessor for a small cluster of processors that have no atomic instructions. Each processor owns one request/response port. It sends a lock, unlock or barrier request that carries a key (normally the address of the shared object) and, for barriers, the number of participants. It then waits for the one-cycle response on its port. A small associative table maps active keys to slots. Each slot owns a first-in first-out queue of waiting port numbers, and that queue is as deep as the number of ports.

A request that cannot be satisfied gets no response. The requester therefore stays blocked, and nobody polls. An unlock hands the lock straight to the oldest waiter. The last arrival at a barrier is answered at once, and the earlier arrivals are then released one per cycle in the order they came. Lock keys and barrier keys are kept apart, so the same value can be in use as a lock and as a barrier at the same time. When no slot is free, the block answers with a table-full status at once, so that software can fall back to another mechanism.

Top module: `qlb_engine`

## Requirements
- R1: At most one request is accepted per cycle. Among the eligible valid requests, the lowest port index wins. `req_ready` is never high without `req_valid` on the same port. After reset, no response is pending.
- R2: A lock on a key that is not held, with a slot free, is granted. The response code is GO (0), and it is seen on the requester's port in the cycle after acceptance.
- R3: A lock on a key that is already held produces no response. The requester's port number joins the tail of that key's queue.
- R4: An unlock on a held key with waiters answers the unlocker with GO. In the same cycle it answers the oldest waiter with GO, which hands the lock to that waiter; the waiters are served in arrival order.
- R5: An unlock on a held key with no waiters frees the slot. A later lock on that key is granted at once, and the freed slot can again hold a new key.
- R6: An unlock whose key is not held as a lock, and any request with the reserved op code 3, is answered with NOKEY (2). Op codes: lock 0, unlock 1, barrier 2.
- R7: A barrier whose participant count is 0 or 1 is answered with GO at once, even when the table is full. A count above the port count is treated as the port count.
- R8: Every barrier arrival before the last one gets no response. The first arrival takes a slot and is queued.
- R9: When the arrival that completes a barrier is accepted, that port gets GO in the next cycle. The queued ports then get GO on the following cycles, one per cycle, in arrival order. The slot is freed with the last release.
- R10: A lock, or a barrier of count two or more, on a key that has no slot gets FULL (1) in the cycle after acceptance when every slot is in use.
- R11: While a barrier release burst is in progress, barrier requests on every port are held off with `req_ready` low. Lock and unlock requests are still accepted.
- R12: Lock and barrier keys occupy separate entries. A barrier key of the same value as a held lock neither waits on that lock nor is released by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_ready | output | N_PORTS | Request accepted this cycle, one bit per port |
| req_op | input | 2*N_PORTS | Op per port: 0 lock, 1 unlock, 2 barrier, 3 reserved |
| req_key | input | KEY_W*N_PORTS | Lock or barrier key per port |
| req_cnt | input | clog2(N_PORTS+1)*N_PORTS | Barrier participant count per port |
| rsp_valid | output | N_PORTS | One-cycle response strobe per port |
| rsp_code | output | 2*N_PORTS | Response per port: 0 GO, 1 FULL, 2 NOKEY |

## Verification
A corrupted slot table would show up as a wrong status on the very next response. A key that was wrongly freed lets a second lock through with GO at once. A key that was wrongly kept makes a later lock stall with no response. A queue pointer that is off by one shows as waiters released in the wrong order, or as the wrong port released, in the cycle right after the unlock or the barrier completion. A release counter that ends early or late shows as a missing or extra response in the burst, and as barrier requests that are held off for the wrong number of cycles.

// File: rtl/qlb_pkg.sv
package qlb_pkg;

  typedef enum logic [1:0] {
    OP_LOCK    = 2'd0,
    OP_UNLOCK  = 2'd1,
    OP_BARRIER = 2'd2,
    OP_RSVD    = 2'd3
  } qlb_op_e;

  typedef enum logic [1:0] {
    RSP_GO    = 2'd0,
    RSP_FULL  = 2'd1,
    RSP_NOKEY = 2'd2
  } qlb_rsp_e;

endpackage

// File: rtl/qlb_prio_arb.sv
// Fixed-priority picker: the lowest set bit wins.
module qlb_prio_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/qlb_wait_fifo.sv
// Circular queue of waiting port numbers for one slot.
module qlb_wait_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/qlb_cam.sv
// Associative slot table: key, kind and barrier count per slot.
module qlb_cam #(
  parameter int S  = 4,
  parameter int KW = 8,
  parameter int CW = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] look_key,
  input  logic          look_bar,
  input  logic          alloc_en,
  input  logic [KW-1:0] alloc_key,
  input  logic          alloc_bar,
  input  logic [CW-1:0] alloc_cnt,
  input  logic [S-1:0]  free_mask,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [CW-1:0] hit_cnt,
  output logic          free_any,
  output logic [IW-1:0] free_idx,
  output logic [S-1:0]  vld
);

  logic [S-1:0]  vld_q, vld_d;
  logic [KW-1:0] key_q [S];
  logic [CW-1:0] cnt_q [S];
  logic [S-1:0]  bar_q;
  logic [S-1:0]  match, hit_oh, free_oh, alloc_oh;

  for (genvar i = 0; i < S; i++) begin : g_slot
    assign match[i] = vld_q[i] && (bar_q[i] == look_bar) && (key_q[i] == look_key);

    always_ff @(posedge clk) begin
      if (alloc_oh[i]) begin
        key_q[i] <= alloc_key;
        bar_q[i] <= alloc_bar;
        cnt_q[i] <= alloc_cnt;
      end
    end
  end

  qlb_prio_arb #(.N(S), .IW(IW)) u_hit_enc (
    .req(match), .gnt(hit_oh), .idx(hit_idx), .any(hit)
  );

  qlb_prio_arb #(.N(S), .IW(IW)) u_free_enc (
    .req(~vld_q), .gnt(free_oh), .idx(free_idx), .any(free_any)
  );

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < S; i++) begin
      if (hit_oh[i]) hit_cnt = hit_cnt | cnt_q[i];
    end
  end

  assign alloc_oh = alloc_en ? free_oh : '0;
  assign vld_d    = (vld_q & ~free_mask) | alloc_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign vld = vld_q;

endmodule

// File: rtl/qlb_engine.sv
module qlb_engine
  import qlb_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_SLOTS = 4,
  parameter int KEY_W   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N_PORTS-1:0]                    req_valid,
  output logic [N_PORTS-1:0]                    req_ready,
  input  logic [2*N_PORTS-1:0]                  req_op,
  input  logic [KEY_W*N_PORTS-1:0]              req_key,
  input  logic [$clog2(N_PORTS+1)*N_PORTS-1:0]  req_cnt,
  output logic [N_PORTS-1:0]                    rsp_valid,
  output logic [2*N_PORTS-1:0]                  rsp_code
);

  localparam int PID_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int SID_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int CNT_W = $clog2(N_PORTS + 1);

  // request selection
  logic [N_PORTS-1:0] elig;
  logic [PID_W-1:0]   sel;
  logic               acc;
  qlb_op_e            s_op;
  logic [KEY_W-1:0]   s_key;
  logic [CNT_W-1:0]   s_cnt_raw, s_cnt;
  logic               look_bar;

  // release burst state
  logic               drain_q, drain_d;
  logic [SID_W-1:0]   dslot_q, dslot_d;
  logic [CNT_W-1:0]   drain_cnt;
  logic [PID_W-1:0]   drain_head;

  // slot table
  logic               hit, free_any, alloc_en;
  logic [SID_W-1:0]   hit_idx, free_idx;
  logic [CNT_W-1:0]   hit_cnt;
  logic [N_SLOTS-1:0] free_mask, slot_vld;

  // queues
  logic [N_SLOTS-1:0] push, pop;
  logic [PID_W-1:0]   q_head [N_SLOTS];
  logic [CNT_W-1:0]   q_cnt  [N_SLOTS];
  logic [CNT_W-1:0]   hit_qcnt;
  logic [PID_W-1:0]   hit_head;

  // responses
  logic [N_PORTS-1:0] rv_q, rv_d;
  logic [1:0]         rc_q [N_PORTS];
  logic [1:0]         rc_d [N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign elig[p] = req_valid[p] &&
                     !(drain_q && (req_op[2*p +: 2] == OP_BARRIER));
    assign rsp_code[2*p +: 2] = rc_q[p];
  end

  qlb_prio_arb #(.N(N_PORTS), .IW(PID_W)) u_arb (
    .req(elig), .gnt(req_ready), .idx(sel), .any(acc)
  );

  assign s_op      = qlb_op_e'(req_op[2*sel +: 2]);
  assign s_key     = req_key[KEY_W*sel +: KEY_W];
  assign s_cnt_raw = req_cnt[CNT_W*sel +: CNT_W];
  assign s_cnt     = (s_cnt_raw > CNT_W'(N_PORTS)) ? CNT_W'(N_PORTS) : s_cnt_raw;
  assign look_bar  = (s_op == OP_BARRIER);

  qlb_cam #(.S(N_SLOTS), .KW(KEY_W), .CW(CNT_W), .IW(SID_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .look_key(s_key), .look_bar(look_bar),
    .alloc_en(alloc_en), .alloc_key(s_key), .alloc_bar(look_bar),
    .alloc_cnt(s_cnt), .free_mask(free_mask),
    .hit(hit), .hit_idx(hit_idx), .hit_cnt(hit_cnt),
    .free_any(free_any), .free_idx(free_idx), .vld(slot_vld)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_queue
    qlb_wait_fifo #(.DEPTH(N_PORTS), .W(PID_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push[s]), .push_data(sel), .pop(pop[s]),
      .head(q_head[s]), .count(q_cnt[s])
    );
  end

  assign hit_qcnt   = q_cnt[hit_idx];
  assign hit_head   = q_head[hit_idx];
  assign drain_cnt  = q_cnt[dslot_q];
  assign drain_head = q_head[dslot_q];

  always_comb begin
    push      = '0;
    pop       = '0;
    free_mask = '0;
    alloc_en  = 1'b0;
    drain_d   = drain_q;
    dslot_d   = dslot_q;
    rv_d      = '0;
    for (int p = 0; p < N_PORTS; p++) rc_d[p] = RSP_GO;

    // one queued barrier waiter released per cycle
    if (drain_q) begin
      pop[dslot_q]     = 1'b1;
      rv_d[drain_head] = 1'b1;
      rc_d[drain_head] = RSP_GO;
      if (drain_cnt == CNT_W'(1)) begin
        free_mask[dslot_q] = 1'b1;
        drain_d            = 1'b0;
      end
    end

    if (acc) begin
      unique case (s_op)
        OP_LOCK: begin
          if (hit) begin
            push[hit_idx] = 1'b1;
          end else if (free_any) begin
            alloc_en  = 1'b1;
            rv_d[sel] = 1'b1;
            rc_d[sel] = RSP_GO;
          end else begin
            rv_d[sel] = 1'b1;
            rc_d[sel] = RSP_FULL;
          end
        end
        OP_UNLOCK: begin
          rv_d[sel] = 1'b1;
          if (hit) begin
            rc_d[sel] = RSP_GO;
            if (hit_qcnt != '0) begin
              pop[hit_idx]   = 1'b1;
              rv_d[hit_head] = 1'b1;
              rc_d[hit_head] = RSP_GO;
            end else begin
              free_mask[hit_idx] = 1'b1;
            end
          end else begin
            rc_d[sel] = RSP_NOKEY;
          end
        end
        OP_BARRIER: begin
          if (s_cnt <= CNT_W'(1)) begin
            rv_d[sel] = 1'b1;
            rc_d[sel] = RSP_GO;
          end else if (hit) begin
            if (hit_qcnt == hit_cnt - CNT_W'(1)) begin
              rv_d[sel] = 1'b1;
              rc_d[sel] = RSP_GO;
              drain_d   = 1'b1;
              dslot_d   = hit_idx;
            end else begin
              push[hit_idx] = 1'b1;
            end
          end else if (free_any) begin
            alloc_en       = 1'b1;
            push[free_idx] = 1'b1;
          end else begin
            rv_d[sel] = 1'b1;
            rc_d[sel] = RSP_FULL;
          end
        end
        default: begin
          rv_d[sel] = 1'b1;
          rc_d[sel] = RSP_NOKEY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      dslot_q <= '0;
      rv_q    <= '0;
      for (int p = 0; p < N_PORTS; p++) rc_q[p] <= RSP_GO;
    end else begin
      drain_q <= drain_d;
      dslot_q <= dslot_d;
      rv_q    <= rv_d;
      for (int p = 0; p < N_PORTS; p++) rc_q[p] <= rc_d[p];
    end
  end

  assign rsp_valid = rv_q;

endmodule

// File: rtl/qlb_engine_chk.sv
module qlb_engine_chk #(
  parameter int N_PORTS = 4,
  parameter int N_SLOTS = 4,
  parameter int CNT_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_PORTS-1:0]   req_valid,
  input logic [N_PORTS-1:0]   req_ready,
  input logic [2*N_PORTS-1:0] req_op,
  input logic [N_PORTS-1:0]   rsp_valid,
  input logic [2*N_PORTS-1:0] rsp_code,
  input logic                 drain_q,
  input logic [CNT_W-1:0]     drain_cnt,
  input logic [N_SLOTS-1:0]   slot_vld
);

  logic bar_taken, full_sent;

  always_comb begin
    bar_taken = 1'b0;
    full_sent = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (req_ready[p] && (req_op[2*p +: 2] == 2'd2)) bar_taken = 1'b1;
      if (rsp_valid[p] && (rsp_code[2*p +: 2] == 2'd1)) full_sent = 1'b1;
    end
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R1
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ready & ~req_valid) == '0)); // R1
  AST_BURST_HOLDS_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> !bar_taken); // R11
  AST_FULL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_sent |-> $past(&slot_vld)); // R10
  AST_BURST_HAS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> (drain_cnt != '0)); // R9

endmodule

bind qlb_engine qlb_engine_chk #(
  .N_PORTS(N_PORTS), .N_SLOTS(N_SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .drain_q(drain_q), .drain_cnt(drain_cnt), .slot_vld(slot_vld)
);

// File: tb/sim_qlb_engine.sv
`timescale 1ns/100ps
module sim_qlb_engine;

  localparam int NP = 4;
  localparam int KW = 8;
  localparam int CW = 3;
  localparam int LK = 0, UL = 1, BR = 2;
  localparam int GO = 0, FULL = 1, NOKEY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]    rv, rdy, rsp_v;
  logic [2*NP-1:0]  rop, rsp_c;
  logic [KW*NP-1:0] rkey;
  logic [CW*NP-1:0] rcnt;

  int cyc = 0;
  int checks = 0, errors = 0;
  int rc_n [NP], rc_code [NP], rc_cyc [NP], base [NP];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qlb_engine #(.N_PORTS(NP), .N_SLOTS(4), .KEY_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rv), .req_ready(rdy), .req_op(rop), .req_key(rkey), .req_cnt(rcnt),
    .rsp_valid(rsp_v), .rsp_code(rsp_c)
  );

  initial for (int p = 0; p < NP; p++) begin rc_n[p] = 0; rc_code[p] = -1; rc_cyc[p] = -1; end

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rsp_v[p]) begin
        rc_n[p]    = rc_n[p] + 1;
        rc_code[p] = int'(rsp_c[2*p +: 2]);
        rc_cyc[p]  = cyc;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int p = 0; p < NP; p++) base[p] = rc_n[p];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic setreq(input int p, input int op, input int key, input int cnt);
    rop[2*p +: 2]   = op[1:0];
    rkey[KW*p +: KW] = key[KW-1:0];
    rcnt[CW*p +: CW] = cnt[CW-1:0];
  endtask

  // returns the cycle number seen right after the accepting edge
  task automatic issue(input int p, input int op, input int key, input int cnt, output int acc);
    setreq(p, op, key, cnt);
    rv[p] = 1'b1;
    #0.5;
    while (!rdy[p]) begin @(negedge clk); #0.5; end
    @(negedge clk);
    acc = cyc;
    rv[p] = 1'b0;
    #0.5;
  endtask

  task automatic expect_rsp(input string tag, input int p, input int code, input int at);
    chk({tag, " count"}, rc_n[p] - base[p], 1);
    chk({tag, " code"}, rc_code[p], code);
    chk({tag, " cycle"}, rc_cyc[p], at);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b;
    rv = '0; rop = '0; rkey = '0; rcnt = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset rsp_valid", int'(rsp_v), 0);
    chk("R1 reset ready", int'(rdy), 0);

    // R2 free lock
    snap(); issue(0, LK, 5, 0, a);
    expect_rsp("R2 lock grant", 0, GO, a);

    // R3 waiters stay silent
    snap(); issue(1, LK, 5, 0, a); issue(2, LK, 5, 0, a); idle(3);
    chk("R3 waiter p1 silent", rc_n[1] - base[1], 0);
    chk("R3 waiter p2 silent", rc_n[2] - base[2], 0);

    // R4 handoff in arrival order
    snap(); issue(0, UL, 5, 0, a);
    expect_rsp("R4 unlocker p0", 0, GO, a);
    expect_rsp("R4 head p1", 1, GO, a);
    chk("R4 p2 still waiting", rc_n[2] - base[2], 0);
    snap(); issue(1, UL, 5, 0, a);
    expect_rsp("R4 unlocker p1", 1, GO, a);
    expect_rsp("R4 next head p2", 2, GO, a);

    // R5 empty queue frees the key
    snap(); issue(2, UL, 5, 0, a);
    expect_rsp("R5 last unlock", 2, GO, a);
    snap(); issue(3, LK, 5, 0, a);
    expect_rsp("R5 relock immediate", 3, GO, a);
    issue(3, UL, 5, 0, a);

    // R6 unknown key and reserved op
    snap(); issue(0, UL, 9, 0, a);
    expect_rsp("R6 unlock unheld", 0, NOKEY, a);
    snap(); issue(1, 3, 9, 0, a);
    expect_rsp("R6 reserved op", 1, NOKEY, a);

    // R7 trivial barriers
    snap(); issue(0, BR, 50, 1, a);
    expect_rsp("R7 count one", 0, GO, a);
    snap(); issue(0, BR, 51, 0, a);
    expect_rsp("R7 count zero", 0, GO, a);

    // R10 table full
    for (int k = 0; k < 4; k++) begin
      snap(); issue(0, LK, 10 + k, 0, a);
      expect_rsp("R10 fill", 0, GO, a);
    end
    snap(); issue(1, LK, 14, 0, a);
    expect_rsp("R10 lock full", 1, FULL, a);
    snap(); issue(1, BR, 14, 2, a);
    expect_rsp("R10 barrier full", 1, FULL, a);
    snap(); issue(1, BR, 14, 1, a);
    expect_rsp("R7 count one while full", 1, GO, a);
    issue(0, UL, 13, 0, a);
    snap(); issue(1, LK, 14, 0, a);
    expect_rsp("R5 freed slot reused", 1, GO, a);
    issue(0, UL, 10, 0, a); issue(0, UL, 11, 0, a); issue(0, UL, 12, 0, a);
    issue(1, UL, 14, 0, a);

    // R8 / R9 barrier of four, arrivals 2,0,1 then 3
    snap();
    issue(2, BR, 7, 4, a); issue(0, BR, 7, 4, a); issue(1, BR, 7, 4, a); idle(2);
    chk("R8 early p2 silent", rc_n[2] - base[2], 0);
    chk("R8 early p0 silent", rc_n[0] - base[0], 0);
    chk("R8 early p1 silent", rc_n[1] - base[1], 0);
    issue(3, BR, 7, 4, a);
    expect_rsp("R9 last arrival", 3, GO, a);
    // R11 barrier held during the burst
    snap();
    setreq(3, BR, 8, 0); rv[3] = 1'b1; #0.5;
    chk("R11 held burst 1", int'(rdy[3]), 0);
    idle(1); chk("R11 held burst 2", int'(rdy[3]), 0);
    idle(1); chk("R11 held burst 3", int'(rdy[3]), 0);
    idle(1); chk("R11 released after burst", int'(rdy[3]), 1);
    @(negedge clk); b = cyc; rv[3] = 1'b0; #0.5;
    expect_rsp("R11 held barrier served", 3, GO, b);
    chk("R9 release p2 first", rc_cyc[2], a + 1);
    chk("R9 release p0 second", rc_cyc[0], a + 2);
    chk("R9 release p1 third", rc_cyc[1], a + 3);

    // R11 lock accepted during a burst
    issue(0, BR, 9, 3, a); issue(1, BR, 9, 3, a);
    snap(); issue(2, BR, 9, 3, a);
    issue(2, LK, 20, 0, b);
    chk("R11 lock during burst cycle", b, a + 1);
    chk("R11 lock during burst code", rc_code[2], GO);
    idle(2);
    expect_rsp("R9 burst p0", 0, GO, a + 1);
    expect_rsp("R9 burst p1", 1, GO, a + 2);
    issue(2, UL, 20, 0, a);

    // R7 count above ports clamps to four
    snap();
    issue(0, BR, 60, 7, a); issue(1, BR, 60, 7, a); issue(2, BR, 60, 7, a); idle(1);
    chk("R7 clamp waits p0", rc_n[0] - base[0], 0);
    issue(3, BR, 60, 7, a); idle(4);
    expect_rsp("R7 clamp last", 3, GO, a);
    expect_rsp("R7 clamp release p2", 2, GO, a + 3);

    // R12 separate lock and barrier keys
    snap(); issue(0, LK, 30, 0, a);
    expect_rsp("R12 lock 30", 0, GO, a);
    issue(1, BR, 30, 2, a);
    snap(); issue(0, UL, 30, 0, a); idle(2);
    expect_rsp("R12 unlock 30", 0, GO, a);
    chk("R12 barrier not released by unlock", rc_n[1] - base[1], 0);
    snap(); issue(2, BR, 30, 2, a); idle(2);
    expect_rsp("R12 barrier completes", 2, GO, a);
    expect_rsp("R12 barrier waiter", 1, GO, a + 1);

    // R1 fixed priority
    snap();
    setreq(1, LK, 40, 0); setreq(2, LK, 42, 0); setreq(3, LK, 41, 0);
    rv = 4'b1110; #0.5;
    chk("R1 lowest first", int'(rdy), 4'b0010);
    @(negedge clk); rv[1] = 1'b0; #0.5;
    chk("R1 next port", int'(rdy), 4'b0100);
    @(negedge clk); rv[2] = 1'b0; #0.5;
    chk("R1 last port", int'(rdy), 4'b1000);
    @(negedge clk); rv[3] = 1'b0; #0.5;
    chk("R1 p1 granted", rc_n[1] - base[1], 1);
    chk("R1 p2 granted", rc_n[2] - base[2], 1);
    chk("R1 p3 granted", rc_n[3] - base[3], 1);
    chk("R1 p3 order", rc_cyc[3] - rc_cyc[1], 2);
    issue(1, UL, 40, 0, a); issue(2, UL, 42, 0, a); issue(3, UL, 41, 0, a);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule